// File: doc/BRIEF.md
# Strided Beat Address Generator

This block produces the bus address for every beat on one side of a DMA channel. A channel uses two instances, one for the read side and one for the write side. Software-facing logic elsewhere loads a start address with a one-cycle start strobe. The transfer engine then pulses a beat strobe once per item moved, and the block moves its address register to the location of the next item.

Four address behaviours are available. Increment mode steps by the item width. Fixed mode holds the address, which suits a peripheral FIFO. Strided mode covers gather on the read side and scatter on the write side: the address runs contiguously for a programmed number of items, then jumps over a gap of a programmed number of items. Both the group size and the gap are counted in item-width units.

An auto-reload option returns the address to its starting value when the last beat of a block is signalled. This lets the same buffer be replayed block after block. There is no data path in this block, so every pin is a plain control or status signal, and there is no back-pressure to manage.

Top module: `gs_addr_gen`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and after it is released, `addr` reads 0 until the first start strobe.
- R2: A `start` pulse loads `start_addr` into `addr` on the next clock edge and restarts the group position. `start` takes priority over a `beat` in the same cycle.
- R3: The item width follows `width_code`: 2'b00 is 1 byte, 2'b01 is 2 bytes, and both 2'b10 and 2'b11 are 4 bytes.
- R4: In increment mode (`mode` 2'b00, and the spare code 2'b11), each beat adds the item width to `addr`. The new value is visible one cycle after the beat.
- R5: In fixed mode (`mode` 2'b01), a beat leaves `addr` unchanged.
- R6: In strided mode (`mode` 2'b10) with a nonzero `grp_count` C and a gap G, each beat adds the width W. On the beat that completes a group of C items, the block adds W*(1+G) instead. After k beats from the start, `addr` is start + (floor(k/C)*(C+G) + k mod C)*W.
- R7: In strided mode, a `grp_count` of 0 makes every beat a plain width increment.
- R8: When `reload_en` is high, a beat with `block_end` high sets `addr` back to the most recent start address and restarts the group position. This takes priority over any increment.
- R9: When `reload_en` is low, a beat with `block_end` high behaves as an ordinary beat: the address and the group position carry on into the next block.
- R10: In any cycle with neither `beat` nor `start`, `addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the start address and save it for reloads |
| start_addr | input | ADDR_W | Initial address of the transfer |
| width_code | input | 2 | Item width code |
| mode | input | 2 | Address behaviour select |
| grp_count | input | CNT_W | Items per contiguous group in strided mode |
| gap_items | input | GAP_W | Items skipped after each group in strided mode |
| beat | input | 1 | One item moved; advance the address |
| block_end | input | 1 | Qualifies the current beat as the last beat of a block |
| reload_en | input | 1 | Return to the start address at block end |
| addr | output | ADDR_W | Current item address |

## Verification
Increment mode is driven at every width code, which confirms that each code maps to its own step and that the spare code matches 4 bytes. Strided mode is tried with a small gap (G=1), a large gap (G=16) and an odd group at 2-byte width (C=3, G=2); this shows that the skip lands on the group's last beat and scales with both the gap and the width. A reload that arrives partway through a group, followed by further beats, shows whether the group position restarts along with the address. The same block-end beat with reload disabled shows that nothing is reset.

// File: rtl/gs_addr_pkg.sv
package gs_addr_pkg;

  typedef enum logic [1:0] {
    AM_INCR  = 2'b00,
    AM_FIXED = 2'b01,
    AM_GS    = 2'b10,
    AM_SPARE = 2'b11
  } addr_mode_e;

  // log2 of the item width in bytes
  function automatic logic [1:0] width_shift(input logic [1:0] code);
    case (code)
      2'b00:   width_shift = 2'd0;
      2'b01:   width_shift = 2'd1;
      default: width_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/gs_group_counter.sv
module gs_group_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  output logic             group_last
);
  logic [CNT_W-1:0] pos_q;

  // out-of-range position (count lowered mid-run) also closes the group
  assign group_last = enable && (pos_q >= count - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos_q <= '0;
    else if (clear)
      pos_q <= '0;
    else if (advance && enable)
      pos_q <= group_last ? '0 : pos_q + 1'b1;
  end
endmodule

// File: rtl/gs_step_calc.sv
module gs_step_calc
  import gs_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GAP_W  = 8
) (
  input  logic [1:0]        width_code,
  input  addr_mode_e        mode,
  input  logic              group_last,
  input  logic [GAP_W-1:0]  gap_items,
  output logic [ADDR_W-1:0] step
);
  logic [1:0]        shamt;
  logic [ADDR_W-1:0] unit;
  logic [ADDR_W-1:0] gap_bytes;

  assign shamt     = width_shift(width_code);
  assign unit      = ADDR_W'(1) << shamt;
  assign gap_bytes = ADDR_W'(gap_items) << shamt;

  always_comb begin
    case (mode)
      AM_FIXED: step = '0;
      AM_GS:    step = group_last ? unit + gap_bytes : unit;
      default:  step = unit;
    endcase
  end
endmodule

// File: rtl/gs_addr_gen.sv
module gs_addr_gen
  import gs_addr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        width_code,
  input  logic [1:0]        mode,
  input  logic [CNT_W-1:0]  grp_count,
  input  logic [GAP_W-1:0]  gap_items,
  input  logic              beat,
  input  logic              block_end,
  input  logic              reload_en,
  output logic [ADDR_W-1:0] addr
);
  addr_mode_e        mode_e;
  logic              do_reload;
  logic              grp_on;
  logic              grp_last;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] shadow_q;

  assign mode_e    = addr_mode_e'(mode);
  assign do_reload = beat && block_end && reload_en;
  assign grp_on    = (mode_e == AM_GS) && (grp_count != '0);

  gs_group_counter #(.CNT_W(CNT_W)) u_grp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start || do_reload),
    .advance    (beat),
    .enable     (grp_on),
    .count      (grp_count),
    .group_last (grp_last)
  );

  gs_step_calc #(.ADDR_W(ADDR_W), .GAP_W(GAP_W)) u_step (
    .width_code (width_code),
    .mode       (mode_e),
    .group_last (grp_last),
    .gap_items  (gap_items),
    .step       (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      shadow_q <= '0;
    end else if (start) begin
      addr_q   <= start_addr;
      shadow_q <= start_addr;
    end else if (do_reload) begin
      addr_q   <= shadow_q;
    end else if (beat) begin
      addr_q   <= addr_q + step;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/gs_addr_gen_chk.sv
module gs_addr_gen_chk
  import gs_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic [1:0]        width_code,
  input logic [1:0]        mode,
  input logic              beat,
  input logic              block_end,
  input logic              reload_en,
  input logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (start) base_q <= start_addr;
  end

  logic plain_beat;
  assign plain_beat = beat && !start && !(block_end && reload_en);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr == $past(start_addr));

  // R4
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_beat && (mode == 2'b00 || mode == 2'b11)) |=>
      addr == $past(addr) + (ADDR_W'(1) << width_shift($past(width_code))));

  // R5
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_beat && mode == 2'b01) |=> $stable(addr));

  // R8
  reload_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && block_end && reload_en && !start) |=> addr == $past(base_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !start) |=> $stable(addr));
endmodule

bind gs_addr_gen gs_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_addr (start_addr),
  .width_code (width_code),
  .mode       (mode),
  .beat       (beat),
  .block_end  (block_end),
  .reload_en  (reload_en),
  .addr       (addr)
);

// File: tb/gs_addr_gen_test.sv
`timescale 1ns/1ps
module gs_addr_gen_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0]    width_code = 2'b10;
  logic [1:0]    mode = 2'b00;
  logic [7:0]    grp_count = '0;
  logic [7:0]    gap_items = '0;
  logic          beat = 1'b0;
  logic          block_end = 1'b0;
  logic          reload_en = 1'b0;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gs_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .width_code(width_code), .mode(mode), .grp_count(grp_count),
    .gap_items(gap_items), .beat(beat), .block_end(block_end),
    .reload_en(reload_en), .addr(addr)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
    end
  endtask

  // one clock with the given strobes; outputs read 1 ns after the edge
  task automatic cycle(input logic b, input logic be, input logic st);
    beat = b; block_end = be; start = st;
    @(posedge clk); #1;
    beat = 1'b0; block_end = 1'b0; start = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a);
    start_addr = a;
    cycle(1'b0, 1'b0, 1'b1);
  endtask

  function automatic logic [AW-1:0] strided(input logic [AW-1:0] b, input int k,
      input int c, input int g, input int w);
    return b + AW'(((k / c) * (c + g) + (k % c)) * w);
  endfunction

  task automatic t_reset();
    check("R1 reset", '0);
    cycle(1'b0, 1'b0, 1'b0);
    check("R1 after reset", '0);
  endtask

  task automatic t_start();
    mode = 2'b00; width_code = 2'b10;
    load(32'h1000);
    check("R2 load", 32'h1000);
    start_addr = 32'h2000;
    cycle(1'b1, 1'b0, 1'b1);
    check("R2 start beats beat", 32'h2000);
  endtask

  task automatic t_incr();
    logic [AW-1:0] exp;
    for (int wc = 0; wc < 4; wc++) begin
      int w;
      w = (wc == 0) ? 1 : (wc == 1) ? 2 : 4;
      width_code = 2'(wc);
      mode = (wc == 3) ? 2'b11 : 2'b00;
      load(32'h300);
      exp = 32'h300;
      for (int i = 0; i < 3; i++) begin
        cycle(1'b1, 1'b0, 1'b0);
        exp = exp + AW'(w);
        check("R3 R4 incr width", exp);
      end
    end
  endtask

  task automatic t_fixed();
    mode = 2'b01; width_code = 2'b10;
    load(32'h4000_0010);
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b0);
    check("R5 fixed", 32'h4000_0010);
  endtask

  task automatic t_strided(input int c, input int g, input int wc, input int w);
    mode = 2'b10; width_code = 2'(wc);
    grp_count = 8'(c); gap_items = 8'(g);
    load(32'h100);
    for (int k = 1; k <= 3 * c + 1; k++) begin
      cycle(1'b1, 1'b0, 1'b0);
      check("R6 strided", strided(32'h100, k, c, g, w));
    end
  endtask

  task automatic t_count_zero();
    mode = 2'b10; width_code = 2'b10; grp_count = 8'd0; gap_items = 8'd5;
    load(32'h800);
    for (int k = 1; k <= 6; k++) begin
      cycle(1'b1, 1'b0, 1'b0);
      check("R7 count zero", 32'h800 + AW'(4 * k));
    end
  endtask

  task automatic t_reload();
    mode = 2'b10; width_code = 2'b10; grp_count = 8'd4; gap_items = 8'd1;
    reload_en = 1'b1;
    load(32'h600);
    for (int k = 1; k <= 6; k++) cycle(1'b1, 1'b0, 1'b0);
    check("R8 pre-reload", strided(32'h600, 6, 4, 1, 4));
    cycle(1'b1, 1'b1, 1'b0);
    check("R8 reload", 32'h600);
    for (int k = 1; k <= 5; k++) begin
      cycle(1'b1, 1'b0, 1'b0);
      check("R8 group restart", strided(32'h600, k, 4, 1, 4));
    end
    reload_en = 1'b0;
  endtask

  task automatic t_no_reload();
    mode = 2'b10; width_code = 2'b10; grp_count = 8'd4; gap_items = 8'd1;
    reload_en = 1'b0;
    load(32'h900);
    for (int k = 1; k <= 6; k++) cycle(1'b1, (k == 3), 1'b0);
    check("R9 continue", strided(32'h900, 6, 4, 1, 4));
    cycle(1'b1, 1'b1, 1'b0);
    check("R9 block end beat", strided(32'h900, 7, 4, 1, 4));
  endtask

  task automatic t_idle();
    logic [AW-1:0] held;
    mode = 2'b00; reload_en = 1'b1;
    held = addr;
    for (int i = 0; i < 4; i++) begin
      block_end = 1'b1;
      @(posedge clk); #1;
    end
    block_end = 1'b0; reload_en = 1'b0;
    check("R10 idle hold", held);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_start();
    t_incr();
    t_fixed();
    t_strided(4, 1, 2, 4);
    t_strided(4, 16, 2, 4);
    t_strided(3, 2, 1, 2);
    t_count_zero();
    t_reload();
    t_no_reload();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule